// File: doc/BRIEF.md
# Sync/Async Serial Transmit Framer

This block turns bytes handed over by a host into a single-bit serial stream. It moves one bit per strobe on a bit-rate enable input. Each byte is taken together with a 6-bit format word. That word selects one of two formats. The raw format shifts out eight bits with no framing. The character format wraps 7 or 8 data bits in a start bit, an optional parity bit and zero, one or two stop bits.

Bytes enter through a one-deep holding register behind a valid/ready handshake. `wr_ready_o` is high whenever the holding register is empty. A byte and its format word are taken on a clock edge where both `wr_valid_i` and `wr_ready_o` are high. The host keeps `wr_valid_i`, `wr_data_i` and `wr_mode_i` steady until that edge. The frame shifter takes the held byte at each frame boundary, so frames run back to back while the host keeps up. When the shifter needs a byte and none is held, the block raises an underflow flag and sends mark until a byte arrives. A global enable gates all transmission.

Top module: `sertx_framer`

## Requirements
- R1: With format bit 5 = 0, the frame is the 8 data bits, bit 0 first, with no start, parity or stop bits.
- R2: With format bit 5 = 1, the frame starts with one start bit at 0, followed by the data bits LSB first. Format bit 0 = 1 sends 8 data bits and 0 sends 7 (bits 0..6).
- R3: Format bit 2 = 1 adds a parity bit after the data. Format bit 1 = 1 gives even parity over the sent data bits, and 0 gives odd parity.
- R4: Format bits 4:3 set the stop bits at 1: 00 gives none, 01 gives one, and 10 or 11 gives two.
- R5: While the enable is high, the serial output changes only on the edge of a one-cycle bit strobe, by one bit per strobe.
- R6: While `tx_en_i` is 0, the serial output is 1 and strobes neither advance a frame nor consume a held byte.
- R7: `wr_ready_o` is 1 when the holding register is empty and drops on the edge that accepts a byte. The format word is captured with the byte.
- R8: A byte accepted while a frame is being sent starts on the strobe right after that frame's last bit, with no idle bit between.
- R9: An enabled strobe at a frame boundary with nothing held sets `underflow_o` and sends 1. The flag stays set, and the output stays 1, until the next accepted byte clears the flag.
- R10: After reset, the serial output is 1, `wr_ready_o` is 1 and `underflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Global transmit enable |
| bit_en_i | input | 1 | One-cycle strobe per serial bit |
| wr_valid_i | input | 1 | Host offers a byte |
| wr_data_i | input | 8 | Byte to send |
| wr_mode_i | input | 6 | Format word captured with the byte |
| wr_ready_o | output | 1 | Holding register empty |
| underflow_o | output | 1 | Shifter was starved of data |
| ser_o | output | 1 | Serial output, 1 = mark |

## Verification
Every serial bit and every underflow set is registered on the edge that carries the strobe, so it is visible one cycle after the strobe is presented. The monitor records the strobe and enable at the rising edge and compares at the following falling edge. `wr_ready_o` falling and `underflow_o` clearing appear on the accepting edge, and the driver samples them just after that edge. Expected bits enter the scoreboard only after the byte is accepted, and the driver never offers a byte in a strobe cycle, so the queue order matches the order in which the shifter takes bytes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned FRAME_W = DW + 4;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  // Layout follows the format word bit order 5..0
  typedef struct packed {
    logic       async_en;
    logic [1:0] stop_sel;
    logic       par_en;
    logic       par_even;
    logic       wide;
  } fmt_t;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
  import sertx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  fmt_t          wr_fmt,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] hold_data,
  output fmt_t          hold_fmt
);
  logic accept;
  assign accept = wr_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
      hold_fmt  <= '0;
    end else if (accept) begin
      full      <= 1'b1;
      hold_data <= wr_data;
      hold_fmt  <= wr_fmt;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
  import sertx_pkg::*;
(
  input  logic [DW-1:0]      data,
  input  fmt_t               fmt,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  logic [CNT_W-1:0] nd;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] stops;
  logic [DW-1:0]    mask;
  logic             par;

  always_comb begin
    nd    = fmt.wide ? CNT_W'(DW) : CNT_W'(DW - 1);
    mask  = fmt.wide ? '1 : ({DW{1'b1}} >> 1);
    par   = ^(data & mask);
    stops = fmt.stop_sel[1] ? CNT_W'(2) : (fmt.stop_sel[0] ? CNT_W'(1) : CNT_W'(0));
    frame = '1;
    pos   = '0;
    if (!fmt.async_en) begin
      frame[DW-1:0] = data;
      len           = CNT_W'(DW);
    end else begin
      frame[0] = 1'b0;
      for (int i = 0; i < DW; i++) begin
        if (CNT_W'(i) < nd) frame[i + 1] = data[i];
      end
      pos = nd + CNT_W'(1);
      if (fmt.par_en) begin
        frame[pos] = fmt.par_even ? par : ~par;
        pos        = pos + CNT_W'(1);
      end
      len = pos + stops;
    end
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               bit_en,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   len,
  output logic               take,
  output logic               starve,
  output logic               ser
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   left;
  logic               step;
  logic               boundary;

  assign step     = tx_en && bit_en;
  assign boundary = (left == '0);
  assign take     = step && boundary && hold_full;
  assign starve   = step && boundary && !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser   <= 1'b1;
      shreg <= '1;
      left  <= '0;
    end else if (!tx_en) begin
      ser <= 1'b1;
    end else if (step) begin
      if (!boundary) begin
        ser   <= shreg[0];
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        left  <= left - CNT_W'(1);
      end else if (hold_full) begin
        ser   <= frame[0];
        shreg <= {1'b1, frame[FRAME_W-1:1]};
        left  <= len - CNT_W'(1);
      end else begin
        ser <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en_i,
  input  logic          bit_en_i,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [5:0]    wr_mode_i,
  output logic          wr_ready_o,
  output logic          underflow_o,
  output logic          ser_o
);
  logic               full;
  logic               take;
  logic               starve;
  logic [DW-1:0]      hold_data;
  fmt_t               hold_fmt;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   len;
  logic               accept;

  assign wr_ready_o = !full;
  assign accept     = wr_valid_i && !full;

  sertx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid_i), .wr_data(wr_data_i),
    .wr_fmt(fmt_t'(wr_mode_i)), .take(take), .full(full),
    .hold_data(hold_data), .hold_fmt(hold_fmt)
  );

  sertx_frame_build u_build (
    .data(hold_data), .fmt(hold_fmt), .frame(frame), .len(len)
  );

  sertx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en_i), .bit_en(bit_en_i),
    .hold_full(full), .frame(frame), .len(len),
    .take(take), .starve(starve), .ser(ser_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      underflow_o <= 1'b0;
    else if (accept) underflow_o <= 1'b0;
    else if (starve) underflow_o <= 1'b1;
  end
endmodule

// File: rtl/sertx_framer_chk.sv
module sertx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en_i,
  input logic bit_en_i,
  input logic wr_valid_i,
  input logic wr_ready_o,
  input logic underflow_o,
  input logic ser_o
);
  AST_DISABLED_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_i |=> ser_o); // R6
  AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_i && !bit_en_i) |=> $stable(ser_o)); // R5
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o) |=> !wr_ready_o); // R7
  AST_UNDERFLOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o) |=> !underflow_o); // R9
  AST_UNDERFLOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> ser_o); // R9
endmodule

bind sertx_framer sertx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en_i), .bit_en_i(bit_en_i),
  .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .underflow_o(underflow_o), .ser_o(ser_o)
);

// File: tb/sertx_framer_tb.sv
module sertx_framer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic [5:0] wr_mode = '0;
  logic       wr_ready, underflow, ser;
  logic [1:0] phase = '0;
  logic       bit_en;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;
  always @(negedge clk) phase <= phase + 2'd1;
  assign bit_en = (phase == 2'd0);

  sertx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .bit_en_i(bit_en),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .wr_mode_i(wr_mode),
    .wr_ready_o(wr_ready), .underflow_o(underflow), .ser_o(ser)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected bit sequence from the format word rules
  task automatic push_frame(input logic [5:0] m, input logic [7:0] d, input string req);
    int  nd;
    bit  p;
    if (!m[5]) begin
      for (int i = 0; i < 8; i++) begin exp_q.push_back(d[i]); tag_q.push_back(req); end
      return;
    end
    nd = m[0] ? 8 : 7;
    exp_q.push_back(1'b0); tag_q.push_back(req);
    p = 1'b0;
    for (int i = 0; i < nd; i++) begin
      exp_q.push_back(d[i]); tag_q.push_back(req); p ^= d[i];
    end
    if (m[2]) begin exp_q.push_back(m[1] ? p : ~p); tag_q.push_back(req); end
    for (int i = 0; i < (m[4] ? 2 : (m[3] ? 1 : 0)); i++) begin
      exp_q.push_back(1'b1); tag_q.push_back(req);
    end
  endtask

  task automatic send(input logic [5:0] m, input logic [7:0] d, input string req);
    do begin @(negedge clk); #1; end while (!(wr_ready && !bit_en));
    wr_valid = 1'b1; wr_data = d; wr_mode = m;
    @(posedge clk); #1;
    wr_valid = 1'b0;
    push_frame(m, d, req);
    check(wr_ready == 1'b0, "R7", wr_ready, 0);
    check(underflow == 1'b0, "R9", underflow, 0);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (!bit_en);
    end
  endtask

  // Scoreboard monitor
  initial begin
    logic st, en, last;
    bit   e;
    string t;
    last = 1'b1;
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      st = bit_en; en = tx_en;
      @(negedge clk);
      if (en && st) begin
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(ser == e, {t, "/R8"}, ser, e);
        end else begin
          check(ser == 1'b1, "R9", ser, 1);
          check(underflow == 1'b1, "R9", underflow, 1);
        end
      end else if (en) begin
        check(ser == last, "R5", ser, last);
      end else begin
        check(ser == 1'b1, "R6", ser, 1);
      end
      last = ser;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ser == 1'b1, "R10", ser, 1);
    check(wr_ready == 1'b1, "R10", wr_ready, 1);
    check(underflow == 1'b0, "R10", underflow, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    tx_en = 1'b1;
    strobes(2);
    @(negedge clk); #1;
    check(underflow == 1'b1, "R9", underflow, 1);
    // Back-to-back frames in several formats
    send(6'b000000, 8'hA5, "R1");
    send(6'b101001, 8'h3C, "R2");
    send(6'b101110, 8'h55, "R3");
    send(6'b110101, 8'h81, "R3");
    send(6'b100000, 8'h7F, "R4");
    send(6'b111001, 8'h00, "R4");
    send(6'b100111, 8'hE3, "R3");
    while (exp_q.size() > 0) @(posedge clk);
    strobes(3);
    // Disabled: held byte must stay held, output at mark
    @(negedge clk); #1;
    tx_en = 1'b0;
    send(6'b101001, 8'hC3, "R6");
    strobes(10);
    @(negedge clk); #1;
    check(wr_ready == 1'b0, "R6", wr_ready, 0);
    check(exp_q.size() == 10, "R6", exp_q.size(), 10);
    tx_en = 1'b1;
    while (exp_q.size() > 0) @(posedge clk);
    strobes(2);
    @(negedge clk); #1;
    check(underflow == 1'b1, "R9", underflow, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule